// File: doc/BRIEF.md
# Hourly Chime Flash Sequencer

This block marks the turn of each hour on a full-colour indicator LED. It watches a running 24-hour time of day, given as six BCD digits. When the time becomes hh:00:00, it flashes the LED a number of times equal to the hour just reached. Midnight (hour 00) is signalled with 24 flashes, so it is never silent.

The time counter supplies a one-cycle pulse once per second. The block only looks for the hour boundary on that pulse, so each hour starts exactly one sequence. Flashes are paced from the system clock: each second-long flash lights the LED for the first half and darks it for the second half. Every flash uses one fixed colour, chosen by a parameter.

The hour value is latched when a sequence starts, so later changes to the time do not alter a sequence already running. While the time is being adjusted, no sequence may start, and any running sequence is cut short with the LED dark.

Top module: `hour_chime`

## Requirements
- R1: After reset, `busy` is 0 and `rgbN` is 3'b111 (all three active-low lines high, LED dark).
- R2: A sequence starts only on a clock cycle where `tick1Hz` is 1 and all four minute and second digits are 0. A pulse at any other minute or second value starts nothing, and neither do zero digits without the pulse.
- R3: The number of flashes equals hourTens×10 + hourUnits. With CLK_HZ clock cycles per second, `busy` stays high for exactly flashes×CLK_HZ cycles.
- R4: Hour 00 produces 24 flashes.
- R5: Within each flash, the LED is lit for the first CLK_HZ/2 cycles and dark for the remaining cycles. The first busy cycle is lit.
- R6: `rgbN` only ever shows 3'b111 (dark) or the bitwise inverse of LIT_MASK (lit). LIT_MASK bit 2 is red, bit 1 is green and bit 0 is blue, and a lit channel is driven 0.
- R7: Changes to the hour digits after a sequence has started do not change its flash count.
- R8: While `adjustActive` is 1, no sequence starts and `rgbN` is 3'b111 in that same cycle. If a sequence is running, `busy` drops on the next clock edge.
- R9: `busy` rises on the edge that samples the start condition and falls when the final dark half has ended. A second hour-boundary pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick1Hz | input | 1 | One-cycle pulse once per second from the time counter |
| hourTens | input | 4 | BCD tens digit of the hour (0 to 2) |
| hourUnits | input | 4 | BCD units digit of the hour |
| minTens | input | 4 | BCD tens digit of the minute |
| minUnits | input | 4 | BCD units digit of the minute |
| secTens | input | 4 | BCD tens digit of the second |
| secUnits | input | 4 | BCD units digit of the second |
| adjustActive | input | 1 | High while the time is being adjusted; blocks and aborts sequences |
| rgbN | output | 3 | Active-low red, green, blue drive lines (bit 2 red, bit 0 blue) |
| busy | output | 1 | High while a chime sequence is running |

## Verification
The bench sweeps all 24 hours. For each sequence it compares every cycle against an arithmetic model of the lit and dark halves, which separates a wrong flash count, a wrong half-period split and a stray colour. Midway through each sequence it changes the hour digits and sends a fresh boundary pulse; this shows whether the count was latched and whether retriggers are ignored. Near-miss times (a non-zero minute or second digit in either position, and zero digits without the pulse) check the start detector. Adjust is exercised both before a start and in the middle of a lit half, which tests the blocking and the abort separately.

// File: rtl/chime_pkg.sv
package chime_pkg;
  // Strobes from the sequencing control to the flash datapath
  typedef struct packed {
    logic load;     // capture flash count, restart phase
    logic clear;    // abandon the running sequence
    logic advance;  // step the phase counter by one cycle
  } chimeStrobes_t;
endpackage

// File: rtl/chime_datapath.sv
module chime_datapath
  import chime_pkg::*;
#(
  parameter int CLK_HZ           = 12_000_000,
  parameter int MIDNIGHT_FLASHES = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  chimeStrobes_t ctl,
  input  logic          tick1Hz,
  input  logic [3:0]    hourTens,
  input  logic [3:0]    hourUnits,
  input  logic [3:0]    minTens,
  input  logic [3:0]    minUnits,
  input  logic [3:0]    secTens,
  input  logic [3:0]    secUnits,
  output logic          hourMark,
  output logic          lastPhase,
  output logic          lastFlash,
  output logic          lightOn
);
  localparam int HALF    = CLK_HZ / 2;
  localparam int PHASE_W = $clog2(CLK_HZ);
  localparam int FLASH_W = 7;  // holds any two-digit BCD value

  logic [PHASE_W-1:0] phaseCnt;
  logic [FLASH_W-1:0] flashLeft;
  logic [FLASH_W-1:0] hourBin;
  logic [FLASH_W-1:0] startCount;

  assign hourMark = tick1Hz && ({minTens, minUnits, secTens, secUnits} == 16'h0000);

  assign hourBin    = FLASH_W'(hourTens) * FLASH_W'(10) + FLASH_W'(hourUnits);
  assign startCount = (hourBin == '0) ? FLASH_W'(MIDNIGHT_FLASHES) : hourBin;

  assign lastPhase = (phaseCnt == PHASE_W'(CLK_HZ - 1));
  assign lastFlash = (flashLeft == FLASH_W'(1));
  assign lightOn   = (phaseCnt < PHASE_W'(HALF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt  <= '0;
      flashLeft <= '0;
    end else if (ctl.load) begin
      phaseCnt  <= '0;
      flashLeft <= startCount;
    end else if (ctl.clear) begin
      phaseCnt  <= '0;
      flashLeft <= '0;
    end else if (ctl.advance) begin
      if (lastPhase) begin
        phaseCnt  <= '0;
        flashLeft <= flashLeft - FLASH_W'(1);
      end else begin
        phaseCnt <= phaseCnt + PHASE_W'(1);
      end
    end
  end
endmodule

// File: rtl/chime_control.sv
module chime_control
  import chime_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          hourMark,
  input  logic          adjustActive,
  input  logic          lastPhase,
  input  logic          lastFlash,
  output chimeStrobes_t ctl,
  output logic          busy
);
  always_comb begin
    ctl = '0;
    if (!busy)             ctl.load    = hourMark && !adjustActive;
    else if (adjustActive) ctl.clear   = 1'b1;
    else                   ctl.advance = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        busy <= 1'b0;
    else if (!busy)                   busy <= ctl.load;
    else if (adjustActive)            busy <= 1'b0;
    else if (lastPhase && lastFlash)  busy <= 1'b0;
  end
endmodule

// File: rtl/hour_chime.sv
module hour_chime
  import chime_pkg::*;
#(
  parameter int         CLK_HZ           = 12_000_000,
  parameter int         MIDNIGHT_FLASHES = 24,
  parameter logic [2:0] LIT_MASK         = 3'b010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick1Hz,
  input  logic [3:0] hourTens,
  input  logic [3:0] hourUnits,
  input  logic [3:0] minTens,
  input  logic [3:0] minUnits,
  input  logic [3:0] secTens,
  input  logic [3:0] secUnits,
  input  logic       adjustActive,
  output logic [2:0] rgbN,
  output logic       busy
);
  chimeStrobes_t ctl;
  logic hourMark, lastPhase, lastFlash, lightOn;

  chime_control ctrl_i (
    .clk(clk), .rstN(rstN), .hourMark(hourMark), .adjustActive(adjustActive),
    .lastPhase(lastPhase), .lastFlash(lastFlash), .ctl(ctl), .busy(busy)
  );

  chime_datapath #(.CLK_HZ(CLK_HZ), .MIDNIGHT_FLASHES(MIDNIGHT_FLASHES)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tick1Hz(tick1Hz),
    .hourTens(hourTens), .hourUnits(hourUnits), .minTens(minTens),
    .minUnits(minUnits), .secTens(secTens), .secUnits(secUnits),
    .hourMark(hourMark), .lastPhase(lastPhase), .lastFlash(lastFlash),
    .lightOn(lightOn)
  );

  assign rgbN = (busy && lightOn && !adjustActive) ? ~LIT_MASK : 3'b111;
endmodule

// File: rtl/hour_chime_checker.sv
module hour_chime_checker #(
  parameter int         CLK_HZ   = 12_000_000,
  parameter logic [2:0] LIT_MASK = 3'b010
) (
  input logic       clk,
  input logic       rstN,
  input logic       tick1Hz,
  input logic [3:0] minTens,
  input logic [3:0] minUnits,
  input logic [3:0] secTens,
  input logic [3:0] secUnits,
  input logic       adjustActive,
  input logic [2:0] rgbN,
  input logic       busy
);
  logic zeroMs;
  int   runLen;

  assign zeroMs = ({minTens, minUnits, secTens, secUnits} == 16'h0000);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else           runLen <= 0;
  end

  AST_START_ON_MARK: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && tick1Hz && zeroMs && !adjustActive) |=> busy); // R2
  AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(tick1Hz && zeroMs)) |=> !busy); // R2
  AST_WHOLE_FLASHES: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(adjustActive)) |-> (runLen > 0 && runLen % CLK_HZ == 0)); // R3
  AST_FIRST_LIT: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !adjustActive) |-> rgbN == ~LIT_MASK); // R5
  AST_ONE_COLOUR: assert property (@(posedge clk) disable iff (!rstN)
    (rgbN == 3'b111) || (rgbN == ~LIT_MASK)); // R6
  AST_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && adjustActive) |=> !busy); // R8
  AST_ADJUST_DARK: assert property (@(posedge clk) disable iff (!rstN)
    adjustActive |-> rgbN == 3'b111); // R8
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !adjustActive && runLen % CLK_HZ != CLK_HZ - 1) |=> busy); // R9
endmodule

bind hour_chime hour_chime_checker #(.CLK_HZ(CLK_HZ), .LIT_MASK(LIT_MASK)) chk_i (
  .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .minTens(minTens),
  .minUnits(minUnits), .secTens(secTens), .secUnits(secUnits),
  .adjustActive(adjustActive), .rgbN(rgbN), .busy(busy)
);

// File: tb/hour_chime_tb.sv
module hour_chime_tb_top;
  localparam int         CLK_HZ = 8;
  localparam int         HALF   = CLK_HZ / 2;
  localparam logic [2:0] LIT    = 3'b010;
  localparam logic [2:0] ON_PAT = 3'b101;
  localparam logic [2:0] OFF    = 3'b111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick1Hz = 1'b0;
  logic [3:0] hourTens = '0, hourUnits = '0, minTens = '0, minUnits = '0;
  logic [3:0] secTens = '0, secUnits = '0;
  logic adjustActive = 1'b0;
  logic [2:0] rgbN;
  logic busy;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  hour_chime #(.CLK_HZ(CLK_HZ), .LIT_MASK(LIT)) dut_i (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .hourTens(hourTens),
    .hourUnits(hourUnits), .minTens(minTens), .minUnits(minUnits),
    .secTens(secTens), .secUnits(secUnits), .adjustActive(adjustActive),
    .rgbN(rgbN), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setTime(input int h, input int m, input int s);
    hourTens  = 4'(h / 10);
    hourUnits = 4'(h % 10);
    minTens   = 4'(m / 10);
    minUnits  = 4'(m % 10);
    secTens   = 4'(s / 10);
    secUnits  = 4'(s % 10);
  endtask

  // returns at the negedge following the edge that sampled the pulse
  task automatic pulseTick();
    @(negedge clk) tick1Hz = 1'b1;
    @(negedge clk) tick1Hz = 1'b0;
  endtask

  task automatic runHour(input int h);
    int n, busyBad, phaseBad, colourBad, litCount, endBusy;
    n = (h == 0) ? 24 : h;
    busyBad = 0; phaseBad = 0; colourBad = 0; litCount = 0;
    setTime(h, 0, 0);
    pulseTick();
    for (int k = 0; k < n * CLK_HZ; k++) begin
      if (busy !== 1'b1) busyBad++;
      if (rgbN !== OFF && rgbN !== ON_PAT) colourBad++;
      if (rgbN !== (((k % CLK_HZ) < HALF) ? ON_PAT : OFF)) phaseBad++;
      if (rgbN === ON_PAT) litCount++;
      if (k == 3) begin
        setTime((h + 7) % 24, 0, 0);
        tick1Hz = 1'b1;
      end
      if (k == 4) tick1Hz = 1'b0;
      @(negedge clk);
    end
    endBusy = busy;
    check(busyBad == 0, "R9 busy held through sequence", busyBad, 0);
    check(phaseBad == 0, "R5 lit/dark halves", phaseBad, 0);
    check(colourBad == 0, "R6 single colour", colourBad, 0);
    if (h == 0) check(litCount == 24 * HALF, "R4 midnight flash count", litCount / HALF, 24);
    else        check(litCount == n * HALF, "R3 flash count", litCount / HALF, n);
    check(endBusy == 0 && rgbN === OFF, "R7 latched count ends on time", endBusy, 0);
    setTime(h, 0, 5);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1 busy in reset", busy, 0);
    check(rgbN === OFF, "R1 LED dark in reset", rgbN, OFF);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && rgbN === OFF, "R1 idle after reset", busy, 0);

    // R2: near misses and zero digits without a pulse
    setTime(5, 0, 1);  pulseTick(); @(negedge clk);
    check(busy === 1'b0, "R2 seconds units nonzero", busy, 0);
    setTime(5, 0, 30); pulseTick(); @(negedge clk);
    check(busy === 1'b0, "R2 seconds tens nonzero", busy, 0);
    setTime(5, 1, 0);  pulseTick(); @(negedge clk);
    check(busy === 1'b0, "R2 minutes units nonzero", busy, 0);
    setTime(5, 10, 0); pulseTick(); @(negedge clk);
    check(busy === 1'b0, "R2 minutes tens nonzero", busy, 0);
    setTime(7, 0, 0);  repeat (10) @(negedge clk);
    check(busy === 1'b0 && rgbN === OFF, "R2 zero digits without pulse", busy, 0);

    // R8: adjust blocks a start
    adjustActive = 1'b1;
    setTime(6, 0, 0); pulseTick(); @(negedge clk);
    check(busy === 1'b0, "R8 no start while adjusting", busy, 0);
    adjustActive = 1'b0;
    setTime(6, 0, 3); @(negedge clk);

    // R8: abort in the middle of a lit half
    setTime(6, 0, 0); pulseTick();
    repeat (10) @(negedge clk);
    check(rgbN === ON_PAT, "R8 lit before abort", rgbN, ON_PAT);
    adjustActive = 1'b1;
    #1;
    check(rgbN === OFF, "R8 dark at once on adjust", rgbN, OFF);
    @(negedge clk);
    check(busy === 1'b0, "R8 busy dropped after abort", busy, 0);
    adjustActive = 1'b0;
    setTime(6, 0, 12);
    repeat (16) @(negedge clk);
    check(busy === 1'b0 && rgbN === OFF, "R8 stays idle after abort", busy, 0);

    // R3 R4 R5 R6 R7 R9: sweep every hour
    for (int h = 0; h < 24; h++) runHour(h);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule